// File: doc/BRIEF.md
# Scaled Countdown Watchdog

The block is a countdown watchdog for a system controller. Software writes a byte count. Each pulse on a one-second tick input, or each group of sixty such pulses when the coarse scale is selected, takes one off the count. A count of zero leaves the watchdog idle. When the count runs out, the block does three things. It sets a sticky fired flag, it drives a system reset output for a fixed number of clock cycles, and it raises one interrupt line chosen by software.

Software keeps the watchdog from firing in one of two ways. It can write the count again. It can also let keyboard or mouse interrupt activity restore the last written count. Software can force a timeout by setting a self-clearing bit. A keyboard-controller line can also force a timeout when it is enabled. The fired flag stays set until software clears it, and no new timeout takes effect while it is set.

Top module: `wdt_scaled`

## Requirements
- R1: Three byte registers sit at reg_addr 0 (control), 1 (count) and 2 (options). Address 3 reads 0. Control bits: 3 is the coarse scale, 2 is the keyboard-line fire enable, 1 is the reset-output enable, and all other control bits read 0. Option bits: 7 is the mouse reload enable, 6 is the keyboard reload enable, 5 is the force bit, 4 is the fired flag, and 3:0 select the interrupt line. After reset, every register reads 0, sys_rst_out is 0 and irq_vec is 0.
- R2: While the count is 0, ticks never change it and no timeout occurs.
- R3: Writing a nonzero N to the count arms the watchdog. With the scale bit 0, each tick takes one off the count, and reading the count returns the remaining value.
- R4: With the scale bit 1, the count drops by one every MIN_TICKS ticks, counted from the last count write or reload.
- R5: The tick that takes the count from 1 to 0 fires the watchdog. The count then stays at 0 and the fired flag (option bit 4) reads 1.
- R6: A firing event with control bit 1 set drives sys_rst_out high for exactly RST_CYCLES clock cycles, starting in the cycle after the event. With control bit 1 clear, sys_rst_out stays low.
- R7: The fired flag is sticky. Writing the options register with bit 4 at 0 clears it, and writing 1 to bit 4 leaves it unchanged. While the flag is set, an expiry or force causes no new reset pulse.
- R8: Writing option bit 5 as 1 fires the watchdog in the next cycle and sets the count to 0. Bit 5 always reads 0.
- R9: With control bit 2 set, a high kbd_p20 fires the watchdog. With control bit 2 clear, kbd_p20 has no effect.
- R10: With option bit 6 (for kbd_irq) or option bit 7 (for mouse_irq) set, a pulse on that input restores the count to the last written value and restarts the coarse-tick phase. This happens only while the count is nonzero. With the enable clear, or with the count at 0, the pulse has no effect.
- R11: While the fired flag is set and the line select L is nonzero, irq_vec has bit L high and all other bits low. L = 2 is the system-management line. When L = 0, or when the flag is clear, irq_vec is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| sec_tick | input | 1 | One-clock pulse once per second |
| kbd_irq | input | 1 | Keyboard interrupt activity |
| mouse_irq | input | 1 | Mouse interrupt activity |
| kbd_p20 | input | 1 | Keyboard-controller line that can force a timeout |
| sys_rst_out | output | 1 | System reset pulse |
| irq_vec | output | 16 | Timeout interrupt lines, one per select value |

## Verification
The bench builds the block with the default MIN_TICKS of 60, so the coarse scale runs at its true ratio. A two-count run therefore stays within a few hundred cycles. RST_CYCLES is set to 5, away from its default, so the measured pulse length shows that the parameter sets the width. With these values the bench can reach every case: a coarse-phase restart partway through a group, expiry on exactly the N-th tick for random N, and the second pulse that is suppressed while the flag is set.

// File: rtl/wdt_pkg.sv
// Shared register addresses, bit positions and field types of the watchdog.
package wdt_pkg;
    typedef enum logic [1:0] {
        WA_CTRL  = 2'd0,
        WA_COUNT = 2'd1,
        WA_OPTS  = 2'd2,
        WA_NONE  = 2'd3
    } wdt_addr_e;

    localparam int CTL_SCALE = 3;
    localparam int CTL_P20   = 2;
    localparam int CTL_RST   = 1;
    localparam int OPT_MOUSE = 7;
    localparam int OPT_KBD   = 6;
    localparam int OPT_FORCE = 5;
    localparam int OPT_FIRED = 4;
    localparam int SEL_W     = 4;

    typedef struct packed {
        logic scale;
        logic p20_en;
        logic rst_en;
    } wdt_ctrl_t;

    typedef struct packed {
        logic             mouse_en;
        logic             kbd_en;
        logic [SEL_W-1:0] line;
    } wdt_opts_t;
endpackage

// File: rtl/wdt_regs.sv
// Register file: holds control, options and reload value, decodes write strobes
// and muxes read data. Assumes one access per cycle, data byte wide.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] cnt_q,
    input  logic              fired_q,
    output wdt_ctrl_t         ctrl,
    output wdt_opts_t         opts,
    output logic [DATA_W-1:0] reload_val,
    output logic              cnt_load,
    output logic              force_req,
    output logic              fired_clr
);
    wdt_addr_e addr;
    assign addr = wdt_addr_e'(reg_addr);

    // Write strobes decoded from the address.
    always_comb begin
        cnt_load  = reg_wr && addr == WA_COUNT;
        force_req = reg_wr && addr == WA_OPTS && reg_wdata[OPT_FORCE];
        fired_clr = reg_wr && addr == WA_OPTS && !reg_wdata[OPT_FIRED];
    end

    // Storage of control, options and last written count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl       <= '0;
            opts       <= '0;
            reload_val <= '0;
        end else if (reg_wr) begin
            case (addr)
                WA_CTRL: begin
                    ctrl.scale  <= reg_wdata[CTL_SCALE];
                    ctrl.p20_en <= reg_wdata[CTL_P20];
                    ctrl.rst_en <= reg_wdata[CTL_RST];
                end
                WA_COUNT: reload_val <= reg_wdata;
                WA_OPTS: begin
                    opts.mouse_en <= reg_wdata[OPT_MOUSE];
                    opts.kbd_en   <= reg_wdata[OPT_KBD];
                    opts.line     <= reg_wdata[SEL_W-1:0];
                end
                default: ;
            endcase
        end
    end

    // Read data multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (addr)
            WA_CTRL: begin
                reg_rdata[CTL_SCALE] = ctrl.scale;
                reg_rdata[CTL_P20]   = ctrl.p20_en;
                reg_rdata[CTL_RST]   = ctrl.rst_en;
            end
            WA_COUNT: reg_rdata = cnt_q;
            WA_OPTS: begin
                reg_rdata[OPT_MOUSE]   = opts.mouse_en;
                reg_rdata[OPT_KBD]     = opts.kbd_en;
                reg_rdata[OPT_FIRED]   = fired_q;
                reg_rdata[SEL_W-1:0]   = opts.line;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_prescale.sv
// Tick prescaler: passes each tick through on the fine scale, or one of every
// MIN_TICKS ticks on the coarse scale. Phase restarts on count load or reload.
module wdt_prescale #(
    parameter int MIN_TICKS = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic scale,
    input  logic run,
    input  logic restart,
    output logic step
);
    localparam int PW = (MIN_TICKS > 2) ? $clog2(MIN_TICKS) : 1;
    localparam logic [PW-1:0] LAST = PW'(MIN_TICKS - 1);

    logic [PW-1:0] pre_q;

    // Step decision from the tick and the current phase.
    assign step = tick && run && (!scale || pre_q == LAST);

    // Phase counter for the coarse scale.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pre_q <= '0;
        end else if (tick && run && scale) begin
            pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_core.sv
// Count register and fired flag. Priority: count write, force or keyboard-line
// fire, activity reload, tick step. A firing event needs the flag clear.
module wdt_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             reload_req,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             step,
    input  logic             force_req,
    input  logic             p20_fire,
    input  logic             fired_clr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             fired_q,
    output logic             reload_take,
    output logic             fire_evt
);
    logic fired_eff;
    logic expire;
    logic armed;

    // Event decode for this cycle.
    always_comb begin
        armed       = cnt_q != '0;
        fired_eff   = fired_q && !fired_clr;
        reload_take = reload_req && armed && !cnt_load;
        expire      = step && cnt_q == CNT_W'(1) && !cnt_load && !reload_take;
        fire_evt    = !fired_eff && (expire || force_req || p20_fire);
    end

    // Count register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_load) begin
            cnt_q <= load_val;
        end else if (force_req || p20_fire) begin
            cnt_q <= '0;
        end else if (reload_take) begin
            cnt_q <= reload_val;
        end else if (step && armed) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Sticky fired flag.
    always_ff @(posedge clk) begin
        if (!rst_n) fired_q <= 1'b0;
        else        fired_q <= fired_eff || fire_evt;
    end
endmodule

// File: rtl/wdt_pulse.sv
// Reset stretcher: a start strobe yields an output high for RST_CYCLES clocks.
module wdt_pulse #(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic pulse
);
    localparam int PW = $clog2(RST_CYCLES + 1);

    logic [PW-1:0] left_q;

    // Remaining pulse length.
    always_ff @(posedge clk) begin
        if (!rst_n)              left_q <= '0;
        else if (start)          left_q <= PW'(RST_CYCLES);
        else if (left_q != '0)   left_q <= left_q - 1'b1;
    end

    assign pulse = left_q != '0;
endmodule

// File: rtl/wdt_scaled.sv
// Scaled countdown watchdog top: registers, prescaler, count core, reset
// stretcher and interrupt line routing. Assumes sec_tick is synchronous.
module wdt_scaled
    import wdt_pkg::*;
#(
    parameter int MIN_TICKS  = 60,
    parameter int RST_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        sec_tick,
    input  logic        kbd_irq,
    input  logic        mouse_irq,
    input  logic        kbd_p20,
    output logic        sys_rst_out,
    output logic [15:0] irq_vec
);
    localparam int DATA_W = 8;
    localparam int LINES  = 1 << SEL_W;

    wdt_ctrl_t         ctrl;
    wdt_opts_t         opts;
    logic [DATA_W-1:0] reload_val;
    logic [DATA_W-1:0] cnt_q;
    logic              fired_q;
    logic              cnt_load;
    logic              force_req;
    logic              fired_clr;
    logic              reload_req;
    logic              reload_take;
    logic              fire_evt;
    logic              step;
    logic              p20_fire;

    wdt_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_q(cnt_q),
        .fired_q(fired_q), .ctrl(ctrl), .opts(opts), .reload_val(reload_val),
        .cnt_load(cnt_load), .force_req(force_req), .fired_clr(fired_clr)
    );

    // Activity reload request and keyboard-line fire.
    assign reload_req = (opts.mouse_en && mouse_irq) || (opts.kbd_en && kbd_irq);
    assign p20_fire   = ctrl.p20_en && kbd_p20;

    wdt_prescale #(.MIN_TICKS(MIN_TICKS)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick), .scale(ctrl.scale),
        .run(cnt_q != '0), .restart(cnt_load || reload_take), .step(step)
    );

    wdt_core #(.CNT_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .cnt_load(cnt_load), .load_val(reg_wdata),
        .reload_req(reload_req), .reload_val(reload_val), .step(step),
        .force_req(force_req), .p20_fire(p20_fire), .fired_clr(fired_clr),
        .cnt_q(cnt_q), .fired_q(fired_q), .reload_take(reload_take),
        .fire_evt(fire_evt)
    );

    wdt_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
        .clk(clk), .rst_n(rst_n), .start(fire_evt && ctrl.rst_en),
        .pulse(sys_rst_out)
    );

    // Interrupt routing: select value 0 drives no line.
    generate
        for (genvar i = 0; i < LINES; i++) begin : g_irq
            if (i == 0) begin : g_none
                assign irq_vec[i] = 1'b0;
            end else begin : g_line
                assign irq_vec[i] = fired_q && opts.line == SEL_W'(i);
            end
        end
    endgenerate
endmodule

// File: rtl/wdt_scaled_chk.sv
// Property checker for wdt_scaled, attached with bind.
module wdt_scaled_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  cnt_q,
    input logic        fired_q,
    input logic        fired_clr,
    input logic        cnt_load,
    input logic        reload_take,
    input logic        step,
    input logic        sys_rst_out,
    input logic [15:0] irq_vec
);
    // R2: an idle count stays idle unless written.
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == 8'd0 && !cnt_load) |=> cnt_q == 8'd0);

    // R3: without a write or reload the count never rises.
    a_r3_no_increase: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_load && !reload_take) |=> cnt_q <= $past(cnt_q));

    // R5: last step fires and leaves count at zero.
    a_r5_expiry_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt_q == 8'd1 && !cnt_load && !reload_take && !fired_q)
        |=> (fired_q && cnt_q == 8'd0));

    // R6: a reset pulse only begins together with a new firing.
    a_r6_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_out) |-> $rose(fired_q));

    // R7: the flag holds until cleared.
    a_r7_fired_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fired_q && !fired_clr) |=> fired_q);

    // R11: at most one line, and none without the flag.
    a_r11_irq_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_vec));
    a_r11_irq_needs_fired: assert property (@(posedge clk) disable iff (!rst_n)
        !fired_q |-> irq_vec == 16'd0);
endmodule

bind wdt_scaled wdt_scaled_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_q(cnt_q), .fired_q(fired_q),
    .fired_clr(fired_clr), .cnt_load(cnt_load), .reload_take(reload_take),
    .step(step), .sys_rst_out(sys_rst_out), .irq_vec(irq_vec)
);

// File: tb/test_wdt_scaled.sv
`timescale 1ns/1ps
module test_wdt_scaled;
    localparam int MIN_T = 60;
    localparam int RSTC  = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        sec_tick = 1'b0;
    logic        kbd_irq = 1'b0;
    logic        mouse_irq = 1'b0;
    logic        kbd_p20 = 1'b0;
    logic        sys_rst_out;
    logic [15:0] irq_vec;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    wdt_scaled #(.MIN_TICKS(MIN_T), .RST_CYCLES(RSTC)) i_wdt_scaled (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_tick(sec_tick),
        .kbd_irq(kbd_irq), .mouse_irq(mouse_irq), .kbd_p20(kbd_p20),
        .sys_rst_out(sys_rst_out), .irq_vec(irq_vec)
    );

    // Remaining count after a number of ticks from a write of n.
    function automatic int exp_left(int n, int ticks, bit coarse);
        int steps;
        steps = coarse ? ticks / MIN_T : ticks;
        return (steps >= n) ? 0 : n - steps;
    endfunction

    // Options byte as built from its fields.
    function automatic logic [7:0] opt_byte(bit m, bit k, bit f, bit keep, int line);
        return {m, k, f, keep, 4'(line)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            sec_tick = 1'b1;
            @(negedge clk);
            sec_tick = 1'b0;
        end
    endtask

    task automatic pulse_len(output int n);
        n = 0;
        while (sys_rst_out && n < 64) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic idle_high(int cycles, output int seen);
        seen = 0;
        for (int i = 0; i < cycles; i++) begin
            if (sys_rst_out) seen++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int n;
        void'($urandom(32'd5417));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, d); check("R1 ctrl reset", d, 0);
        rd(2'd1, d); check("R1 count reset", d, 0);
        rd(2'd2, d); check("R1 opts reset", d, 0);
        check("R1 outputs reset", {sys_rst_out, irq_vec}, 0);

        // R1 field layout
        wr(2'd0, 8'hFF); rd(2'd0, d); check("R1 ctrl fields", d, 8'h0E);
        wr(2'd2, 8'hCF); rd(2'd2, d); check("R1 opts fields", d, 8'hCF);
        rd(2'd3, d); check("R1 spare addr", d, 0);
        wr(2'd0, 8'h00); wr(2'd2, 8'h00);

        // R2 zero count stays idle
        ticks(100);
        rd(2'd1, d); check("R2 count idle", d, 0);
        rd(2'd2, d); check("R2 not fired", d[4], 0);

        // R3 R5 R6 R11 random fine-scale runs
        for (int it = 0; it < 6; it++) begin
            int nn;
            nn = $urandom_range(1, 20);
            wr(2'd0, 8'h02);
            wr(2'd2, opt_byte(0, 0, 0, 0, 2));
            wr(2'd1, 8'(nn));
            for (int k = 1; k < nn; k++) begin
                ticks(1);
                rd(2'd1, d); check("R3 remaining", d, exp_left(nn, k, 0));
                check("R3 no early fire", irq_vec, 0);
            end
            ticks(1);
            #1 check("R11 smi line", irq_vec, 16'h0004);
            pulse_len(n); check("R6 pulse length", n, RSTC);
            rd(2'd1, d); check("R5 count zero", d, 0);
            rd(2'd2, d); check("R5 fired flag", d, 8'h12);
        end

        // R7 sticky: rearm without clearing gives no new pulse
        wr(2'd1, 8'd3);
        ticks(3);
        idle_high(RSTC + 3, n); check("R7 no second pulse", n, 0);
        rd(2'd2, d); check("R7 still fired", d[4], 1);
        wr(2'd2, opt_byte(0, 0, 0, 0, 2));
        rd(2'd2, d); check("R7 cleared", d[4], 0);

        // R4 coarse scale, two counts
        wr(2'd0, 8'h0A);
        wr(2'd1, 8'd2);
        ticks(MIN_T - 1); rd(2'd1, d); check("R4 before first step", d, exp_left(2, MIN_T - 1, 1));
        ticks(1);         rd(2'd1, d); check("R4 first step", d, exp_left(2, MIN_T, 1));
        ticks(MIN_T - 1); rd(2'd1, d); check("R4 before expiry", d, 1);
        check("R4 not yet fired", irq_vec, 0);
        ticks(1);
        #1 check("R4 expiry irq", irq_vec, 16'h0004);
        wr(2'd2, opt_byte(0, 0, 0, 0, 2));

        // R10 reload restarts coarse phase
        wr(2'd2, opt_byte(0, 1, 0, 0, 2));
        wr(2'd1, 8'd2);
        ticks(30);
        kbd_irq = 1'b1; @(negedge clk); kbd_irq = 1'b0;
        ticks(MIN_T - 1); rd(2'd1, d); check("R10 phase restarted", d, 2);
        ticks(1);         rd(2'd1, d); check("R10 step after restart", d, 1);
        wr(2'd0, 8'h02);

        // R10 fine scale reload enables
        wr(2'd2, opt_byte(0, 0, 0, 0, 2));
        wr(2'd1, 8'd10);
        ticks(4);
        kbd_irq = 1'b1; mouse_irq = 1'b1; @(negedge clk); kbd_irq = 1'b0; mouse_irq = 1'b0;
        rd(2'd1, d); check("R10 disabled ignored", d, 6);
        wr(2'd2, opt_byte(0, 1, 0, 0, 2));
        kbd_irq = 1'b1; @(negedge clk); kbd_irq = 1'b0;
        rd(2'd1, d); check("R10 kbd reload", d, 10);
        ticks(3);
        wr(2'd2, opt_byte(1, 0, 0, 0, 2));
        mouse_irq = 1'b1; @(negedge clk); mouse_irq = 1'b0;
        rd(2'd1, d); check("R10 mouse reload", d, 10);
        wr(2'd1, 8'd0);
        mouse_irq = 1'b1; @(negedge clk); mouse_irq = 1'b0;
        rd(2'd1, d); check("R10 zero count ignored", d, 0);

        // R8 force fires at once, bit reads back 0
        wr(2'd1, 8'd10);
        wr(2'd2, opt_byte(0, 0, 1, 0, 2));
        #1 check("R8 forced irq", irq_vec, 16'h0004);
        rd(2'd1, d); check("R8 count zero", d, 0);
        rd(2'd2, d); check("R8 force reads 0", d, 8'h12);

        // R11 line select 0 and 5
        wr(2'd2, opt_byte(0, 0, 0, 1, 0));
        #1 check("R11 line zero", irq_vec, 0);
        wr(2'd2, opt_byte(0, 0, 0, 1, 5));
        #1 check("R11 line five", irq_vec, 16'h0020);
        wr(2'd2, opt_byte(0, 0, 0, 0, 2));

        // R9 keyboard line ignored then honoured
        wr(2'd1, 8'd9);
        kbd_p20 = 1'b1; @(negedge clk); kbd_p20 = 1'b0;
        rd(2'd1, d); check("R9 ignored count", d, 9);
        rd(2'd2, d); check("R9 ignored flag", d[4], 0);
        wr(2'd0, 8'h06);
        kbd_p20 = 1'b1; @(negedge clk); kbd_p20 = 1'b0;
        #1 check("R9 fired irq", irq_vec, 16'h0004);
        pulse_len(n); check("R9 pulse", n, RSTC);

        // R6 no pulse with reset enable clear
        wr(2'd0, 8'h00);
        wr(2'd2, opt_byte(0, 0, 0, 0, 2));
        wr(2'd1, 8'd1);
        ticks(1);
        idle_high(RSTC + 3, n); check("R6 pulse disabled", n, 0);
        rd(2'd2, d); check("R6 fired anyway", d[4], 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule